// File: doc/BRIEF.md
# LCD Interrupt Status and Mask Unit

This block collects the event pulses of a display controller's seven fetch channels and the frame-level events of the controller. Each event sets a sticky bit in one of two status registers. It reduces those bits, filtered by mask bits held in two control registers, to a single registered interrupt request. Channel 0 events and controller-wide events go to the primary status register. Events from channels 1 to 6 go to a packed secondary register that has one byte-wide lane per event type.

Software reaches the control, status and interrupt-ID registers through a small synchronous register port. It clears status bits by writing ones to them. When an event that would itself raise the interrupt arrives while the request line is already high, the block marks a secondary interrupt and keeps the frame ID of the channel that caused it, so that software can tell which frame arrived second.

Top module: `lcd_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is low.
- R2: A start-of-frame event (kind 0) sets status only if bit 22 of `evt_cmd` is 1. For channel 0 it sets primary bit 1. For channel k (1..6) it sets secondary bit k-1.
- R3: An end-of-frame event (kind 1) sets status only if bit 21 of `evt_cmd` is 1. For channel 0 it sets primary bit 8. For channel k it sets secondary bit k+7.
- R4: A branch event (kind 2) sets primary bit 9 for channel 0, or secondary bit k+15 for channel k.
- R5: A bus-error event (kind 3) sets primary bit 2 and writes the channel number into primary bits 30:28. While bit 2 is 0, bits 30:28 are 0.
- R6: A read-status event (kind 4) sets primary bit 11. A quick-disable event (kind 5) sets bit 7. A last-frame-done event (kind 6) sets bit 0.
- R7: A write to control 0 (address 0) that clears bit 0 while the stored bit 0 is 1 sets primary bit 7.
- R8: The cycle after status or masks change, `irq` equals the OR of the following terms: each primary bit ANDed with the inverse of its mask bit, and the secondary status ANDed with the inverse of the channel mask (address 1). The primary bits and their control-0 mask bits are 0/3, 1/4, 4/5, 6/21, 7/11, 8/6, 9/20, 11/23 and 12/24. Primary bit 5 uses channel-mask bit 24. Primary bits 2, 3 and 10 never drive `irq`.
- R9: An event of kind 0-4 that would raise `irq` unmasked, arriving while `irq` is high, sets primary bit 10. For kinds 0-3 it also copies `evt_fid` into the interrupt-ID register (address 4). A bus error always counts as unmasked.
- R10: A write to primary status (address 2) clears each bit of 11:0 written as 1. Writing 1 to bit 2 also clears bits 30:28.
- R11: A write to secondary status (address 3) clears only the bits written as 1 within 0x3E3F3F, so the branch bit of channel 1 (bit 16) cannot be cleared.
- R12: If an event and a software clear hit the same status bit in one cycle, the bit ends up set.
- R13: The following have no effect: events on channel 7 or of kind 7, writes to address 4 or above, and control bits outside 0x07FFFFFF (address 0) or 0x3F3F3F3F (address 1), which read as 0.
- R14: `reg_rdata` presents, one cycle after `reg_addr`, the value the addressed register held in that cycle. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 ctrl0, 1 channel mask, 2 primary status, 3 secondary status, 4 interrupt ID) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_valid | input | 1 | Event pulse |
| evt_kind | input | 3 | Event type code |
| evt_chan | input | 3 | Channel that raised the event |
| evt_cmd | input | 32 | Current command word of that channel |
| evt_fid | input | 32 | Frame ID of that channel |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions can fall in the same cycle: an event setting a status bit, and a software write clearing that same bit. The bench provokes this directly by raising a start-of-frame on channel 0 in the same cycle as a write of ones to primary status. The random phase also lets events and writes to addresses 2 and 3 overlap freely. Each outcome is judged against a bench model in which the set term wins over the clear term. Secondary-interrupt capture is judged the same way, because it depends on the `irq` value in the cycle of the event.

// File: rtl/lcdint_pkg.sv
package lcdint_pkg;

  localparam int W = 32;

  typedef enum logic [2:0] {
    EV_SOF    = 3'd0,
    EV_EOF    = 3'd1,
    EV_BRANCH = 3'd2,
    EV_BUSERR = 3'd3,
    EV_RDST   = 3'd4,
    EV_QDIS   = 3'd5,
    EV_LDONE  = 3'd6,
    EV_NONE   = 3'd7
  } evt_kind_e;

  // primary status bit positions
  localparam int P_LDONE = 0;
  localparam int P_SOF   = 1;
  localparam int P_BER   = 2;
  localparam int P_IU0   = 4;
  localparam int P_IU1   = 5;
  localparam int P_OU    = 6;
  localparam int P_QD    = 7;
  localparam int P_EOF   = 8;
  localparam int P_BS    = 9;
  localparam int P_SINT  = 10;
  localparam int P_RDST  = 11;
  localparam int P_CMD   = 12;
  localparam int P_BCH   = 28;

  // control 0 mask bit positions
  localparam int C_EN      = 0;
  localparam int C_M_LDONE = 3;
  localparam int C_M_SOF   = 4;
  localparam int C_M_IU0   = 5;
  localparam int C_M_EOF   = 6;
  localparam int C_M_QD    = 11;
  localparam int C_M_BS    = 20;
  localparam int C_M_OU    = 21;
  localparam int C_M_RDST  = 23;
  localparam int C_M_CMD   = 24;
  localparam int CM_M_IU1  = 24;

  // command word gate bits
  localparam int CMD_EOFI = 21;
  localparam int CMD_SOFI = 22;

  // lane bases in the secondary register (channel k uses base + k - 1)
  localparam logic [4:0] L_SOF = 5'd0;
  localparam logic [4:0] L_EOF = 5'd8;
  localparam logic [4:0] L_BS  = 5'd16;
  localparam logic [4:0] L_IU  = 5'd24;

  localparam logic [W-1:0] CTRL0_KEEP = 32'h07ff_ffff;
  localparam logic [W-1:0] CMASK_KEEP = 32'h3f3f_3f3f;
  localparam logic [W-1:0] S0_CLR     = 32'h0000_0fff;
  localparam logic [W-1:0] S1_CLR     = 32'h003e_3f3f;

  localparam logic [2:0] RA_CTRL0 = 3'd0;
  localparam logic [2:0] RA_CMASK = 3'd1;
  localparam logic [2:0] RA_STAT0 = 3'd2;
  localparam logic [2:0] RA_STAT1 = 3'd3;
  localparam logic [2:0] RA_IID   = 3'd4;

endpackage

// File: rtl/lcdint_evt_decode.sv
module lcdint_evt_decode
  import lcdint_pkg::*;
#(
  parameter int NCHAN = 7
) (
  input  logic         evt_valid,
  input  logic [2:0]   evt_kind,
  input  logic [2:0]   evt_chan,
  input  logic [W-1:0] evt_cmd,
  input  logic [W-1:0] ctrl0,
  input  logic [W-1:0] cmask,
  output logic [W-1:0] set0,
  output logic [W-1:0] set1,
  output logic         ber_hit,
  output logic         unmasked,
  output logic         take_id
);

  logic       chan_ok;
  logic       is_ch0;
  logic [4:0] lane;
  evt_kind_e  kind;

  assign chan_ok = (32'(evt_chan) < NCHAN);
  assign is_ch0  = (evt_chan == 3'd0);
  assign lane    = {2'b00, evt_chan - 3'd1};
  assign kind    = evt_kind_e'(evt_kind);

  always_comb begin
    set0     = '0;
    set1     = '0;
    ber_hit  = 1'b0;
    unmasked = 1'b0;
    take_id  = 1'b0;
    if (evt_valid && chan_ok) begin
      unique case (kind)
        EV_SOF: if (evt_cmd[CMD_SOFI]) begin
          take_id = 1'b1;
          if (is_ch0) begin
            set0[P_SOF] = 1'b1;
            unmasked    = !ctrl0[C_M_SOF];
          end else begin
            set1[L_SOF + lane] = 1'b1;
            unmasked           = !cmask[L_SOF + lane];
          end
        end
        EV_EOF: if (evt_cmd[CMD_EOFI]) begin
          take_id = 1'b1;
          if (is_ch0) begin
            set0[P_EOF] = 1'b1;
            unmasked    = !ctrl0[C_M_EOF];
          end else begin
            set1[L_EOF + lane] = 1'b1;
            unmasked           = !cmask[L_EOF + lane];
          end
        end
        EV_BRANCH: begin
          take_id = 1'b1;
          if (is_ch0) begin
            set0[P_BS] = 1'b1;
            unmasked   = !ctrl0[C_M_BS];
          end else begin
            set1[L_BS + lane] = 1'b1;
            unmasked          = !cmask[L_BS + lane];
          end
        end
        EV_BUSERR: begin
          set0[P_BER] = 1'b1;
          ber_hit     = 1'b1;
          unmasked    = 1'b1;
          take_id     = 1'b1;
        end
        EV_RDST: begin
          set0[P_RDST] = 1'b1;
          unmasked     = !ctrl0[C_M_RDST];
        end
        EV_QDIS:  set0[P_QD]    = 1'b1;
        EV_LDONE: set0[P_LDONE] = 1'b1;
        default: ;
      endcase
    end
  end

  logic unused_dec;
  assign unused_dec = ^{evt_cmd, ctrl0};

endmodule

// File: rtl/lcdint_regport.sv
module lcdint_regport
  import lcdint_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic [W-1:0]      stat0,
  input  logic [W-1:0]      stat1,
  input  logic [W-1:0]      iid,
  output logic [W-1:0]      ctrl0,
  output logic [W-1:0]      cmask,
  output logic              wr_stat0,
  output logic              wr_stat1,
  output logic              qd_set,
  output logic [W-1:0]      reg_rdata
);

  localparam int NREG = 5;

  logic [NREG-1:0] hit;
  logic [W-1:0]    rd_mux;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_hit
      assign hit[g] = (32'(reg_addr) == g);
    end
  endgenerate

  assign wr_stat0 = reg_wr && hit[RA_STAT0];
  assign wr_stat1 = reg_wr && hit[RA_STAT1];
  assign qd_set   = reg_wr && hit[RA_CTRL0] && ctrl0[C_EN] && !reg_wdata[C_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0 <= '0;
      cmask <= '0;
    end else if (reg_wr) begin
      if (hit[RA_CTRL0]) ctrl0 <= reg_wdata & CTRL0_KEEP;
      if (hit[RA_CMASK]) cmask <= reg_wdata & CMASK_KEEP;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit[RA_CTRL0]) rd_mux = ctrl0;
    if (hit[RA_CMASK]) rd_mux = cmask;
    if (hit[RA_STAT0]) rd_mux = stat0;
    if (hit[RA_STAT1]) rd_mux = stat1;
    if (hit[RA_IID])   rd_mux = iid;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/lcdint_status.sv
module lcdint_status
  import lcdint_pkg::*;
#(
  parameter int NCHAN = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set0,
  input  logic [W-1:0] set1,
  input  logic         ber_hit,
  input  logic [2:0]   ber_chan,
  input  logic         second,
  input  logic         take_id,
  input  logic [W-1:0] fid,
  input  logic         qd_set,
  input  logic         wr_stat0,
  input  logic         wr_stat1,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat0,
  output logic [W-1:0] stat1,
  output logic [W-1:0] iid
);

  // lanes that exist for the configured channel count
  logic [W-1:0] lane_mask;
  genvar k;
  generate
    for (k = 0; k < 8; k++) begin : g_lane
      if (k >= 1 && k < NCHAN) begin : g_on
        assign lane_mask[k-1]      = 1'b1;
        assign lane_mask[k+7]      = 1'b1;
        assign lane_mask[k+15]     = 1'b1;
        assign lane_mask[k+23]     = 1'b1;
      end else if (k >= 1) begin : g_off
        assign lane_mask[k-1]      = 1'b0;
        assign lane_mask[k+7]      = 1'b0;
        assign lane_mask[k+15]     = 1'b0;
        assign lane_mask[k+23]     = 1'b0;
      end else begin : g_pad
        assign lane_mask[7]  = 1'b0;
        assign lane_mask[15] = 1'b0;
        assign lane_mask[23] = 1'b0;
        assign lane_mask[31] = 1'b0;
      end
    end
  endgenerate

  logic [W-1:0] clr0, clr1, add0, nxt0, nxt1;

  always_comb begin
    clr0 = wr_stat0 ? (wdata & S0_CLR) : '0;
    clr1 = wr_stat1 ? (wdata & S1_CLR) : '0;
    add0 = set0;
    add0[P_SINT] = add0[P_SINT] | second;
    add0[P_QD]   = add0[P_QD] | qd_set;
    nxt0 = (stat0 & ~clr0) | add0;
    if (ber_hit)
      nxt0[P_BCH +: 3] = ber_chan;
    else if (wr_stat0 && wdata[P_BER])
      nxt0[P_BCH +: 3] = 3'd0;
    nxt1 = ((stat1 & ~clr1) | set1) & lane_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat0 <= '0;
      stat1 <= '0;
      iid   <= '0;
    end else begin
      stat0 <= nxt0;
      stat1 <= nxt1;
      if (second && take_id) iid <= fid;
    end
  end

endmodule

// File: rtl/lcdint_irq.sv
module lcdint_irq
  import lcdint_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat0,
  input  logic [W-1:0] stat1,
  input  logic [W-1:0] ctrl0,
  input  logic [W-1:0] cmask,
  output logic         irq
);

  logic [9:0] prim;
  logic       pend;

  assign prim[0] = stat0[P_LDONE] & ~ctrl0[C_M_LDONE];
  assign prim[1] = stat0[P_SOF]   & ~ctrl0[C_M_SOF];
  assign prim[2] = stat0[P_IU0]   & ~ctrl0[C_M_IU0];
  assign prim[3] = stat0[P_IU1]   & ~cmask[CM_M_IU1];
  assign prim[4] = stat0[P_OU]    & ~ctrl0[C_M_OU];
  assign prim[5] = stat0[P_QD]    & ~ctrl0[C_M_QD];
  assign prim[6] = stat0[P_EOF]   & ~ctrl0[C_M_EOF];
  assign prim[7] = stat0[P_BS]    & ~ctrl0[C_M_BS];
  assign prim[8] = stat0[P_RDST]  & ~ctrl0[C_M_RDST];
  assign prim[9] = stat0[P_CMD]   & ~ctrl0[C_M_CMD];

  assign pend = (|prim) | (|(stat1 & ~cmask));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= pend;
  end

  logic unused_irq;
  assign unused_irq = ^{stat0, ctrl0};

endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
  import lcdint_pkg::*;
#(
  parameter int NCHAN  = 7,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evt_valid,
  input  logic [2:0]        evt_kind,
  input  logic [2:0]        evt_chan,
  input  logic [31:0]       evt_cmd,
  input  logic [31:0]       evt_fid,
  output logic              irq
);

  logic [W-1:0] ctrl0_q, cmask_q, stat0_q, stat1_q, iid_q;
  logic [W-1:0] set0, set1;
  logic ber_hit, unmasked, take_id, second;
  logic wr_stat0, wr_stat1, qd_set;

  lcdint_regport #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat0(stat0_q), .stat1(stat1_q), .iid(iid_q),
    .ctrl0(ctrl0_q), .cmask(cmask_q), .wr_stat0(wr_stat0),
    .wr_stat1(wr_stat1), .qd_set(qd_set), .reg_rdata(reg_rdata)
  );

  lcdint_evt_decode #(.NCHAN(NCHAN)) u_dec (
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_chan(evt_chan),
    .evt_cmd(evt_cmd), .ctrl0(ctrl0_q), .cmask(cmask_q),
    .set0(set0), .set1(set1), .ber_hit(ber_hit),
    .unmasked(unmasked), .take_id(take_id)
  );

  // a second unmasked event while the request is already up
  assign second = unmasked && irq;

  lcdint_status #(.NCHAN(NCHAN)) u_stat (
    .clk(clk), .rst(rst), .set0(set0), .set1(set1), .ber_hit(ber_hit),
    .ber_chan(evt_chan), .second(second), .take_id(take_id), .fid(evt_fid),
    .qd_set(qd_set), .wr_stat0(wr_stat0), .wr_stat1(wr_stat1),
    .wdata(reg_wdata), .stat0(stat0_q), .stat1(stat1_q), .iid(iid_q)
  );

  lcdint_irq u_irq (
    .clk(clk), .rst(rst), .stat0(stat0_q), .stat1(stat1_q),
    .ctrl0(ctrl0_q), .cmask(cmask_q), .irq(irq)
  );

endmodule

// File: rtl/lcd_irq_unit_chk.sv
module lcd_irq_unit_chk #(
  parameter int NCHAN  = 7,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              evt_valid,
  input logic [2:0]        evt_chan,
  input logic              irq,
  input logic [31:0]       ctrl0_q,
  input logic [31:0]       stat0_q,
  input logic [31:0]       stat1_q,
  input logic [31:0]       iid_q
);

  // R2
  sof0_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat0_q[1] && !(reg_wr && 32'(reg_addr) == 2)) |=> stat0_q[1]);

  // R5
  berch_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !stat0_q[2] |-> (stat0_q[30:28] == 3'd0));

  // R13
  bad_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && 32'(evt_chan) >= NCHAN && !reg_wr) |=>
      ($stable(stat0_q) && $stable(stat1_q)));

  // R9
  iid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(iid_q) |-> stat0_q[10]);

  // R7
  qd_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && 32'(reg_addr) == 0 && ctrl0_q[0] && !reg_wdata[0]) |=> stat0_q[7]);

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (stat0_q == 32'd0 && stat1_q == 32'd0) |=> !irq);

  // R4
  stat1_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (stat1_q & 32'hc0c0_c0c0) == 32'd0);

endmodule

bind lcd_irq_unit lcd_irq_unit_chk #(.NCHAN(NCHAN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_valid(evt_valid), .evt_chan(evt_chan),
  .irq(irq), .ctrl0_q(ctrl0_q), .stat0_q(stat0_q), .stat1_q(stat1_q),
  .iid_q(iid_q)
);

// File: tb/lcd_irq_unit_bench.sv
module lcd_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_kind = 3'd7;
  logic [2:0]  evt_chan = 3'd0;
  logic [31:0] evt_cmd = 32'd0;
  logic [31:0] evt_fid = 32'd0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_c0, m_c5, m_s0, m_s1, m_iid;
  logic        m_irq;

  lcd_irq_unit u_lcd_irq_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_chan(evt_chan), .evt_cmd(evt_cmd),
    .evt_fid(evt_fid), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic pending(logic [31:0] c0, logic [31:0] c5,
                                   logic [31:0] s0, logic [31:0] s1);
    logic p;
    p = (s0[0] & ~c0[3]) | (s0[1] & ~c0[4]) | (s0[4] & ~c0[5]) |
        (s0[5] & ~c5[24]) | (s0[6] & ~c0[21]) | (s0[7] & ~c0[11]) |
        (s0[8] & ~c0[6]) | (s0[9] & ~c0[20]) | (s0[11] & ~c0[23]) |
        (s0[12] & ~c0[24]);
    return p | (|(s1 & ~c5));
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return m_c0;
      3'd1: return m_c5;
      3'd2: return m_s0;
      3'd3: return m_s1;
      3'd4: return m_iid;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_c0 = 0; m_c5 = 0; m_s0 = 0; m_s1 = 0; m_iid = 0; m_irq = 0;
  endtask

  task automatic model_step();
    logic [31:0] s0a, s1a, n0, n1;
    logic unm, cap, ber, sec, qd, nirq;
    int lane;
    s0a = 0; s1a = 0; unm = 0; cap = 0; ber = 0;
    lane = int'(evt_chan) - 1;
    if (evt_valid && evt_chan != 3'd7) begin
      case (evt_kind)
        3'd0: if (evt_cmd[22]) begin
          cap = 1;
          if (evt_chan == 0) begin s0a[1] = 1; unm = !m_c0[4]; end
          else begin s1a[lane] = 1; unm = !m_c5[lane]; end
        end
        3'd1: if (evt_cmd[21]) begin
          cap = 1;
          if (evt_chan == 0) begin s0a[8] = 1; unm = !m_c0[6]; end
          else begin s1a[lane+8] = 1; unm = !m_c5[lane+8]; end
        end
        3'd2: begin
          cap = 1;
          if (evt_chan == 0) begin s0a[9] = 1; unm = !m_c0[20]; end
          else begin s1a[lane+16] = 1; unm = !m_c5[lane+16]; end
        end
        3'd3: begin s0a[2] = 1; ber = 1; unm = 1; cap = 1; end
        3'd4: begin s0a[11] = 1; unm = !m_c0[23]; end
        3'd5: s0a[7] = 1;
        3'd6: s0a[0] = 1;
        default: ;
      endcase
    end
    sec = unm && m_irq;
    qd  = reg_wr && reg_addr == 3'd0 && m_c0[0] && !reg_wdata[0];
    if (sec) s0a[10] = 1;
    if (qd)  s0a[7] = 1;
    n0 = m_s0;
    n1 = m_s1;
    if (reg_wr && reg_addr == 3'd2) begin
      n0 = n0 & ~(reg_wdata & 32'hfff);
      if (reg_wdata[2]) n0[30:28] = 0;
    end
    if (reg_wr && reg_addr == 3'd3) n1 = n1 & ~(reg_wdata & 32'h003e3f3f);
    n0 = n0 | s0a;
    if (ber) n0[30:28] = evt_chan;
    n1 = n1 | s1a;
    nirq = pending(m_c0, m_c5, m_s0, m_s1);
    if (sec && cap) m_iid = evt_fid;
    if (reg_wr && reg_addr == 3'd0) m_c0 = reg_wdata & 32'h07ffffff;
    if (reg_wr && reg_addr == 3'd1) m_c5 = reg_wdata & 32'h3f3f3f3f;
    m_s0 = n0; m_s1 = n1; m_irq = nirq;
  endtask

  // one clock with checks of irq and read data after the edge
  task automatic cyc(input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    exp_rd = model_read(reg_addr);
    exp_irq = pending(m_c0, m_c5, m_s0, m_s1);
    model_step();
    @(posedge clk);
    #2;
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s irq: actual %0b expected %0b", tag, irq, exp_irq);
    end
    checks++;
    if (reg_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata: actual %08h expected %08h", tag, reg_rdata, exp_rd);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] k, input logic [2:0] ch,
                       input logic [31:0] cmd, input logic [31:0] fid,
                       input logic w, input logic [2:0] a, input logic [31:0] d);
    evt_valid = v; evt_kind = k; evt_chan = ch; evt_cmd = cmd; evt_fid = fid;
    reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle_read(input logic [2:0] a, input string tag);
    drive(0, 3'd7, 0, 0, 0, 0, a, 0);
    cyc(tag);
  endtask

  task automatic ev(input logic [2:0] k, input logic [2:0] ch,
                    input logic [31:0] cmd, input logic [31:0] fid, input string tag);
    drive(1, k, ch, cmd, fid, 0, 3'd0, 0);
    cyc(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    drive(0, 3'd7, 0, 0, 0, 1, a, d);
    cyc(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // R1 reset values
    for (int a = 0; a < 5; a++) idle_read(3'(a), "R1");

    // R2 start-of-frame gating and lanes
    ev(3'd0, 3'd0, 32'h0, 32'h11, "R2");
    idle_read(3'd2, "R2");
    ev(3'd0, 3'd0, 32'h0040_0000, 32'h12, "R2");
    ev(3'd0, 3'd3, 32'h0040_0000, 32'h13, "R2");
    idle_read(3'd2, "R2");
    idle_read(3'd3, "R2");

    // R3 end-of-frame
    ev(3'd1, 3'd6, 32'h0, 32'h21, "R3");
    ev(3'd1, 3'd0, 32'h0020_0000, 32'h22, "R3");
    ev(3'd1, 3'd6, 32'h0020_0000, 32'h23, "R3");
    idle_read(3'd2, "R3");
    idle_read(3'd3, "R3");

    // R4 branch
    ev(3'd2, 3'd0, 0, 32'h31, "R4");
    ev(3'd2, 3'd1, 0, 32'h32, "R4");
    ev(3'd2, 3'd5, 0, 32'h33, "R4");
    idle_read(3'd3, "R4");

    // R5 bus error with channel number
    ev(3'd3, 3'd4, 0, 32'h41, "R5");
    idle_read(3'd2, "R5");
    ev(3'd3, 3'd2, 0, 32'h42, "R5");
    idle_read(3'd2, "R5");

    // R9 secondary interrupt with frame ID capture
    ev(3'd0, 3'd2, 32'h0040_0000, 32'hABCD_1234, "R9");
    idle_read(3'd4, "R9");
    idle_read(3'd2, "R9");

    // R6 other events
    ev(3'd4, 3'd0, 0, 32'h51, "R6");
    ev(3'd5, 3'd1, 0, 32'h52, "R6");
    ev(3'd6, 3'd0, 0, 32'h53, "R6");
    idle_read(3'd2, "R6");

    // R10 primary clear
    wr(3'd2, 32'hFFFF_FFFF, "R10");
    idle_read(3'd2, "R10");

    // R11 secondary clear, channel 1 branch bit stays
    wr(3'd3, 32'hFFFF_FFFF, "R11");
    idle_read(3'd3, "R11");

    // R12 event and clear of same bit in one cycle
    ev(3'd0, 3'd0, 32'h0040_0000, 32'h61, "R12");
    drive(1, 3'd0, 3'd0, 32'h0040_0000, 32'h62, 1, 3'd2, 32'h0000_0002);
    cyc("R12");
    idle_read(3'd2, "R12");

    // R7 enable fall sets quick-disable
    wr(3'd2, 32'hFFF, "R7");
    wr(3'd0, 32'h1, "R7");
    wr(3'd0, 32'h0, "R7");
    idle_read(3'd2, "R7");

    // R13 ignored stimuli
    wr(3'd2, 32'hFFF, "R13");
    ev(3'd0, 3'd7, 32'hFFFF_FFFF, 32'h71, "R13");
    ev(3'd7, 3'd0, 32'hFFFF_FFFF, 32'h72, "R13");
    wr(3'd4, 32'h5555_5555, "R13");
    idle_read(3'd4, "R13");
    wr(3'd0, 32'hFFFF_FFFF, "R13");
    wr(3'd1, 32'hFFFF_FFFF, "R13");
    idle_read(3'd0, "R13");
    idle_read(3'd1, "R13");

    // R8 masks hold irq low; bus error alone never raises it
    ev(3'd0, 3'd0, 32'h0040_0000, 32'h81, "R8");
    ev(3'd2, 3'd3, 0, 32'h82, "R8");
    idle_read(3'd2, "R8");
    wr(3'd0, 32'h0, "R8");
    idle_read(3'd2, "R8");
    wr(3'd2, 32'hFFF, "R8");
    wr(3'd3, 32'hFFFF_FFFF, "R8");
    wr(3'd1, 32'h0001_0000, "R8");
    ev(3'd3, 3'd1, 0, 32'h83, "R8");
    idle_read(3'd2, "R8");
    idle_read(3'd2, "R8");

    // R14 random mix of events and register traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0], 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
            $urandom, $urandom, (r[3:1] < 3'd2), 3'($urandom_range(0, 5)),
            (r[4] ? 32'h0 : $urandom));
      cyc("R14");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule